// File: doc/BRIEF.md
# Linked-Descriptor Peripheral DMA Engine

This block moves 32-bit words between system memory and a single peripheral data register. Work is described by a chain of eight-word descriptors stored in memory; the engine fetches a descriptor, moves the number of words it names (each word paced by the peripheral's request line), optionally pulses an interrupt, and then follows the link to the next descriptor. A link whose low bit is set continues the chain, and a link that points back to an earlier descriptor forms an endless ring.

Software drives the engine through one control register. A write carries a 64-byte-aligned address together with command bits. The start command begins fetching a chain at that address. The query command makes the engine dump its live descriptor, with progress so far, to that address. The stop command halts the transfer at the next word boundary. Restarting from a dumped descriptor resumes an interrupted transfer. All memory traffic, including the peripheral register accesses, goes through one word-wide master port with a request/ready handshake.

Top module: `chain_dma`

## Requirements
- R1: After reset no memory request is issued, the interrupt is low, and the control readback is zero except the channel field [1:0], which reads the CHAN_ID parameter (default 1).
- R2: A control write whose bits [1:0] differ from CHAN_ID is ignored: no command becomes pending and no memory access follows.
- R3: A control write with bit 3 set (start) and address bits [31:6] makes the engine fetch the eight descriptor words from that 64-byte-aligned address. Readback bit 3 reads 1 until the fetch is taken up, one cycle later when idle, and 0 afterwards.
- R4: Descriptor word order at byte offsets 0..28 is: link, memory address, device address, length, stride, cycles, command, status. While a memory request waits for ready, its address, direction and write data stay unchanged.
- R5: With command bit 12 clear, each word is read from the device address and written to the memory address. One word moves only while the peripheral request input is high, and each completed word gives a one-cycle acknowledge pulse.
- R6: With command bit 12 set, each word is read from the memory address and written to the device address. The memory address advances by 4 per word and the device address never changes.
- R7: The length word counts 32-bit words. Exactly that many words move, and a length of 0 moves none but still completes the descriptor.
- R8: When bit 0 of the link word is set, the next descriptor is fetched from the link with bits [1:0] cleared. When that bit is clear, the engine goes idle after the descriptor.
- R9: On descriptor completion the interrupt output pulses high for exactly one cycle if command bit 1 is set and command bit 0 (mask) is clear, and stays low otherwise.
- R10: A link pointing back to an earlier descriptor makes the engine loop without end, raising an interrupt for every enabled descriptor on every lap.
- R11: A control write with bit 2 set (query) makes the engine write eight words to the given address in descriptor order. The memory address and length words show the progress so far, the status word is 1 when a chain was active and 0 when idle, and readback bit 2 stays 1 until the last word is written.
- R12: A control write with bit 4 set (stop) halts the engine at the next word boundary, and no further word moves. If query and stop are written together, the dump comes first. A later start at the dumped address resumes the transfer exactly where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write value: address [31:6], stop [4], start [3], query [2], channel [1:0] |
| ctl_rdata | output | 32 | Control register readback |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the access in this cycle |
| mem_rdata | input | 32 | Memory read data, valid when mem_ready is high |
| per_req | input | 1 | Peripheral ready for one word |
| per_ack | output | 1 | One-cycle pulse after each word completes |
| irq | output | 1 | One-cycle descriptor-completion interrupt |

## Verification
The two functions that can collide are the query dump and the stop. One control write sets both bits while a transfer is parked between words, so both become pending in the same cycle. The bench then checks that the dumped image still reports a busy engine, with the memory address and remaining length of exactly three words done. It also checks that no further word moves once the peripheral asserts its request again, and that restarting from the dumped image produces the same eight consecutive destination values as an uninterrupted transfer.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_RD,
    S_WR,
    S_DONE,
    S_DUMP
  } seq_state_t;

  // control word field positions
  localparam int CTL_ADDR_LSB  = 6;
  localparam int CTL_STOP_BIT  = 4;
  localparam int CTL_START_BIT = 3;
  localparam int CTL_QUERY_BIT = 2;

  // command word field positions
  localparam int CMD_TO_DEV_BIT = 12;
  localparam int CMD_INT_BIT    = 1;
  localparam int CMD_MASK_BIT   = 0;

  // descriptor layout
  localparam int DESC_WORDS = 8;
  localparam int WI_NEXT    = 0;
  localparam int WI_MADDR   = 1;
  localparam int WI_DADDR   = 2;
  localparam int WI_LEN     = 3;
  localparam int WI_CMD     = 6;
  localparam int WI_STAT    = 7;

endpackage

// File: rtl/chain_dma_ctl.sv
module chain_dma_ctl
  import chain_dma_pkg::*;
#(
  parameter int CHAN_W  = 2,
  parameter int CHAN_ID = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        take_start,
  input  logic        take_query,
  input  logic        take_stop,
  output logic        start_pend,
  output logic        query_pend,
  output logic        stop_pend,
  output logic [31:0] start_addr,
  output logic [31:0] query_addr,
  output logic [31:0] rd_data
);

  logic hit;
  logic set_start, set_query, set_stop;
  logic start_q, query_q, stop_q;
  logic start_d, query_d, stop_d;
  logic shown_en;
  logic [31:5] shown_q;
  logic [31:CTL_ADDR_LSB] saddr_q, qaddr_q;

  always_comb begin
    hit       = wr_en && (wr_data[CHAN_W-1:0] == CHAN_ID[CHAN_W-1:0]);
    set_start = hit && wr_data[CTL_START_BIT];
    set_query = hit && wr_data[CTL_QUERY_BIT];
    set_stop  = hit && wr_data[CTL_STOP_BIT];
    shown_en  = set_start || set_query;
    start_d   = set_start || (start_q && !take_start);
    query_d   = set_query || (query_q && !take_query);
    stop_d    = set_stop  || (stop_q  && !take_stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      query_q <= 1'b0;
      stop_q  <= 1'b0;
      shown_q <= '0;
      saddr_q <= '0;
      qaddr_q <= '0;
    end else begin
      start_q <= start_d;
      query_q <= query_d;
      stop_q  <= stop_d;
      if (shown_en)  shown_q <= wr_data[31:5];
      if (set_start) saddr_q <= wr_data[31:CTL_ADDR_LSB];
      if (set_query) qaddr_q <= wr_data[31:CTL_ADDR_LSB];
    end
  end

  always_comb begin
    rd_data                = '0;
    rd_data[31:5]          = shown_q;
    rd_data[CTL_STOP_BIT]  = stop_q;
    rd_data[CTL_START_BIT] = start_q;
    rd_data[CTL_QUERY_BIT] = query_q;
    rd_data[CHAN_W-1:0]    = CHAN_ID[CHAN_W-1:0];
  end

  assign start_pend = start_q;
  assign query_pend = query_q;
  assign stop_pend  = stop_q;
  assign start_addr = {saddr_q, {CTL_ADDR_LSB{1'b0}}};
  assign query_addr = {qaddr_q, {CTL_ADDR_LSB{1'b0}}};

  assert_chan_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit && !take_start && !take_query && !take_stop)
      |=> ($stable(start_pend) && $stable(query_pend) && $stable(stop_pend)));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_start && !set_start) |=> !start_pend);

  assert_query_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_query && !set_query) |=> !query_pend);

endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
  import chain_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_pend,
  input  logic [31:0] start_addr,
  input  logic        query_pend,
  input  logic [31:0] query_addr,
  input  logic        stop_pend,
  output logic        take_start,
  output logic        take_query,
  output logic        take_stop,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  input  logic        per_req,
  output logic        per_ack,
  output logic        desc_done,
  output logic        int_req,
  output logic        int_mask
);

  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(WI_STAT);

  seq_state_t state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0] base_q, base_d;
  logic ret_q, ret_d;
  logic [31:0] data_q;
  logic ack_q;
  logic [31:0] desc_q [DESC_WORDS];

  logic desc_ld, data_ld, adv;
  logic to_dev, last_idx, len_zero;
  logic [31:0] word_off, dump_word;

  always_comb begin
    to_dev    = desc_q[WI_CMD][CMD_TO_DEV_BIT];
    last_idx  = (idx_q == LAST_IDX);
    len_zero  = (desc_q[WI_LEN] == 32'd0);
    word_off  = {{(30-IDX_W){1'b0}}, idx_q, 2'b00};
    dump_word = (idx_q == STAT_IDX) ? {31'd0, ret_q} : desc_q[idx_q];
  end

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    base_d     = base_q;
    ret_d      = ret_q;
    desc_ld    = 1'b0;
    data_ld    = 1'b0;
    adv        = 1'b0;
    take_start = 1'b0;
    take_query = 1'b0;
    take_stop  = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = base_q + word_off;
    mem_wdata  = '0;
    case (state_q)
      S_IDLE: begin
        if (query_pend) begin
          state_d = S_DUMP;
          base_d  = query_addr;
          idx_d   = '0;
          ret_d   = 1'b0;
        end else if (start_pend) begin
          take_start = 1'b1;
          state_d    = S_FETCH;
          base_d     = start_addr;
          idx_d      = '0;
        end else if (stop_pend) begin
          take_stop = 1'b1;
        end
      end
      S_FETCH: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          desc_ld = 1'b1;
          if (last_idx) state_d = S_WAIT;
          else          idx_d   = idx_q + IDX_W'(1);
        end
      end
      S_WAIT: begin
        if (query_pend) begin
          state_d = S_DUMP;
          base_d  = query_addr;
          idx_d   = '0;
          ret_d   = 1'b1;
        end else if (stop_pend) begin
          take_stop = 1'b1;
          state_d   = S_IDLE;
        end else if (len_zero) begin
          state_d = S_DONE;
        end else if (per_req) begin
          state_d = S_RD;
        end
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = to_dev ? desc_q[WI_MADDR] : desc_q[WI_DADDR];
        if (mem_ready) begin
          data_ld = 1'b1;
          state_d = S_WR;
        end
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = to_dev ? desc_q[WI_DADDR] : desc_q[WI_MADDR];
        mem_wdata = data_q;
        if (mem_ready) begin
          adv     = 1'b1;
          state_d = S_WAIT;
        end
      end
      S_DONE: begin
        if (desc_q[WI_NEXT][0]) begin
          state_d = S_FETCH;
          base_d  = {desc_q[WI_NEXT][31:2], 2'b00};
          idx_d   = '0;
        end else begin
          state_d = S_IDLE;
        end
      end
      S_DUMP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = dump_word;
        if (mem_ready) begin
          if (last_idx) begin
            take_query = 1'b1;
            state_d    = ret_q ? S_WAIT : S_IDLE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      ret_q   <= 1'b0;
      data_q  <= '0;
      ack_q   <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      ret_q   <= ret_d;
      ack_q   <= adv;
      if (data_ld) data_q <= mem_rdata;
      if (desc_ld) desc_q[idx_q] <= mem_rdata;
      if (adv) begin
        desc_q[WI_MADDR] <= desc_q[WI_MADDR] + 32'd4;
        desc_q[WI_LEN]   <= desc_q[WI_LEN] - 32'd1;
      end
    end
  end

  assign per_ack   = ack_q;
  assign desc_done = (state_q == S_DONE);
  assign int_req   = desc_q[WI_CMD][CMD_INT_BIT];
  assign int_mask  = desc_q[WI_CMD][CMD_MASK_BIT];

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready)
      |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

  assert_stop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    take_stop |=> !mem_req);

endmodule

// File: rtl/chain_dma_irq.sv
module chain_dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic int_req,
  input  logic int_mask,
  output logic irq
);

  logic irq_q, irq_d;

  always_comb irq_d = done && int_req && !int_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int CHAN_W  = 2,
  parameter int CHAN_ID = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  input  logic        per_req,
  output logic        per_ack,
  output logic        irq
);

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic start_pend, query_pend, stop_pend;
  logic take_start, take_query, take_stop;
  logic [31:0] start_addr, query_addr;
  logic desc_done, int_req, int_mask;

  chain_dma_ctl #(
    .CHAN_W  (CHAN_W),
    .CHAN_ID (CHAN_ID)
  ) ctl_i (
    .clk        (clk),
    .rst_n      (rst_i),
    .wr_en      (ctl_we),
    .wr_data    (ctl_wdata),
    .take_start (take_start),
    .take_query (take_query),
    .take_stop  (take_stop),
    .start_pend (start_pend),
    .query_pend (query_pend),
    .stop_pend  (stop_pend),
    .start_addr (start_addr),
    .query_addr (query_addr),
    .rd_data    (ctl_rdata)
  );

  chain_dma_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_i),
    .start_pend (start_pend),
    .start_addr (start_addr),
    .query_pend (query_pend),
    .query_addr (query_addr),
    .stop_pend  (stop_pend),
    .take_start (take_start),
    .take_query (take_query),
    .take_stop  (take_stop),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .per_req    (per_req),
    .per_ack    (per_ack),
    .desc_done  (desc_done),
    .int_req    (int_req),
    .int_mask   (int_mask)
  );

  chain_dma_irq irq_i (
    .clk      (clk),
    .rst_n    (rst_i),
    .done     (desc_done),
    .int_req  (int_req),
    .int_mask (int_mask),
    .irq      (irq)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rst_i) |-> (!mem_req && !irq));

endmodule

// File: tb/chain_dma_tb_top.sv
`timescale 1ns/1ps
module chain_dma_tb_top;

  localparam logic [31:0] DEV_RD = 32'h3F0;
  localparam logic [31:0] DEV_WR = 32'h3F4;
  localparam logic [31:0] CH     = 32'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic per_req = 1'b0;
  logic per_ack, irq;

  always #5 clk = ~clk;

  chain_dma dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .per_req(per_req), .per_ack(per_ack), .irq(irq)
  );

  // memory model, single writer process
  logic [31:0] mem [1024];
  logic [31:0] dev_log [16];
  int log_n, ack_cnt, irq_cnt, acc_cnt;
  logic [4:0] lfsr;
  logic stall_en = 1'b0;
  logic tb_we = 1'b0;
  logic [31:0] tb_a = '0, tb_d = '0;

  assign mem_ready = mem_req && (!stall_en || lfsr[0]);
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
      log_n <= 0; ack_cnt <= 0; irq_cnt <= 0; acc_cnt <= 0;
      lfsr <= 5'd1;
    end else begin
      lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      if (tb_we) mem[tb_a[11:2]] <= tb_d;
      if (mem_req && mem_ready) begin
        acc_cnt <= acc_cnt + 1;
        if (mem_we) begin
          mem[mem_addr[11:2]] <= mem_wdata;
          if (mem_addr == DEV_WR) begin
            dev_log[log_n[3:0]] <= mem_wdata;
            log_n <= log_n + 1;
          end
        end
      end
      if (per_ack) begin
        mem[DEV_RD[11:2]] <= mem[DEV_RD[11:2]] + 32'd1;
        ack_cnt <= ack_cnt + 1;
      end
      if (irq) irq_cnt <= irq_cnt + 1;
    end
  end

  int vec = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = a; tb_d = d;
  endtask

  task automatic poke_end();
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] nxt,
                          input logic [31:0] ma, input logic [31:0] da,
                          input logic [31:0] len, input logic [31:0] cmd);
    poke(at,       nxt);
    poke(at + 4,   ma);
    poke(at + 8,   da);
    poke(at + 12,  len);
    poke(at + 16,  32'd0);
    poke(at + 20,  32'd1);
    poke(at + 24,  cmd);
    poke(at + 28,  32'd0);
    poke_end();
  endtask

  task automatic ctl_write(input logic [31:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int target, input string tag);
    int n;
    n = 0;
    while (irq_cnt < target && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (irq_cnt < target) begin
      vec++; bad++;
      $display("FAIL %s: interrupt count %0d expected %0d", tag, irq_cnt, target);
    end
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int a0, i0, c0, k;
    repeat (4) @(negedge clk);
    check("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    idle(4);
    check("R1 readback", ctl_rdata, CH);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2: wrong channel
    c0 = acc_cnt;
    ctl_write(32'h100 | 32'h8 | 32'd0);
    check("R2 readback unchanged", ctl_rdata, CH);
    idle(20);
    check("R2 no access", acc_cnt - c0, 0);

    // R5/R7/R9/R8: device to memory, single descriptor
    poke(DEV_RD, 32'h1000); poke_end();
    put_desc(32'h100, 32'h0, 32'h400, DEV_RD, 32'd5, 32'h2);
    a0 = ack_cnt; i0 = irq_cnt;
    per_req = 1'b1;
    ctl_write(32'h100 | 32'h8 | CH);
    check("R3 start pending bit", {31'd0, ctl_rdata[3]}, 32'd1);
    check("R3 readback address", {6'd0, ctl_rdata[31:6]}, 32'd4);
    @(negedge clk);
    check("R3 start bit cleared", {31'd0, ctl_rdata[3]}, 32'd0);
    check("R3 fetch address", mem_addr, 32'h100);
    check("R4 fetch request", {31'd0, mem_req}, 32'd1);
    wait_irq(i0 + 1, "R9 dev2mem");
    idle(20);
    for (int i = 0; i < 5; i++)
      check("R5 word", rd(32'h400 + 4 * i), 32'h1000 + i);
    check("R7 no extra word", rd(32'h414), 32'd0);
    check("R5 ack count", ack_cnt - a0, 5);
    check("R9 one interrupt", irq_cnt - i0, 1);
    check("R8 idle after chain end", {31'd0, mem_req}, 32'd0);

    // R6/R7/R8/R9: memory to device chain with zero-length, masked link
    stall_en = 1'b1;
    for (int i = 0; i < 5; i++) poke(32'h500 + 4 * i, 32'hA0 + i);
    poke_end();
    put_desc(32'h200, 32'h221, 32'h500, DEV_WR, 32'd3, 32'h1002);
    put_desc(32'h220, 32'h241, 32'h600, DEV_WR, 32'd0, 32'h1003);
    put_desc(32'h240, 32'h0,   32'h50C, DEV_WR, 32'd2, 32'h1002);
    a0 = ack_cnt; i0 = irq_cnt;
    ctl_write(32'h200 | 32'h8 | CH);
    wait_irq(i0 + 2, "R8 chain");
    idle(40);
    check("R6 device writes", log_n, 5);
    for (int i = 0; i < 5; i++)
      check("R6 device data order", dev_log[i], 32'hA0 + i);
    check("R7 zero length moves nothing", ack_cnt - a0, 5);
    check("R9 masked descriptor silent", irq_cnt - i0, 2);
    check("R7 source untouched", rd(32'h600), 32'd0);

    // R10/R12: ring, then stop
    put_desc(32'h280, 32'h2A1, 32'h700, DEV_RD, 32'd2, 32'h2);
    put_desc(32'h2A0, 32'h281, 32'h710, DEV_RD, 32'd2, 32'h2);
    i0 = irq_cnt;
    ctl_write(32'h280 | 32'h8 | CH);
    wait_irq(i0 + 6, "R10 ring laps");
    check("R10 ring keeps looping", {31'd0, (irq_cnt - i0) >= 6}, 32'd1);
    check("R10 consecutive words", rd(32'h704), rd(32'h700) + 1);
    check("R10 second descriptor", rd(32'h714), rd(32'h710) + 1);
    ctl_write(32'h10 | CH);
    idle(40);
    a0 = ack_cnt; i0 = irq_cnt;
    idle(100);
    check("R12 ring halted words", ack_cnt - a0, 0);
    check("R12 ring halted irq", irq_cnt - i0, 0);
    check("R12 bus quiet", {31'd0, mem_req}, 32'd0);

    // R11/R12: query and stop together, then resume
    stall_en = 1'b0;
    per_req = 1'b0;
    poke(DEV_RD, 32'h2000); poke_end();
    put_desc(32'h100, 32'h0, 32'h800, DEV_RD, 32'd8, 32'h2);
    a0 = ack_cnt; i0 = irq_cnt;
    ctl_write(32'h100 | 32'h8 | CH);
    idle(30);
    check("R5 no word without request", ack_cnt - a0, 0);
    check("R5 destination untouched", rd(32'h800), 32'd0);
    per_req = 1'b1;
    k = 0;
    while (k < 3) begin
      @(negedge clk);
      if (per_ack) k++;
    end
    per_req = 1'b0;
    ctl_write(32'h640 | 32'h10 | 32'h4 | CH);
    k = 0;
    while (ctl_rdata[2] && k < 1000) begin
      @(negedge clk);
      k++;
    end
    idle(4);
    check("R11 query bit cleared", {31'd0, ctl_rdata[2]}, 32'd0);
    check("R11 dump link", rd(32'h640), 32'h0);
    check("R11 dump memory address", rd(32'h644), 32'h80C);
    check("R11 dump device address", rd(32'h648), DEV_RD);
    check("R11 dump length", rd(32'h64C), 32'd5);
    check("R11 dump cycles", rd(32'h654), 32'd1);
    check("R11 dump command", rd(32'h658), 32'h2);
    check("R11 dump status busy", rd(32'h65C), 32'd1);
    per_req = 1'b1;
    idle(40);
    check("R12 stopped after query", ack_cnt - a0, 3);
    ctl_write(32'h640 | 32'h8 | CH);
    wait_irq(i0 + 1, "R12 resume");
    idle(10);
    for (int i = 0; i < 8; i++)
      check("R12 resumed data", rd(32'h800 + 4 * i), 32'h2000 + i);
    check("R12 total words", ack_cnt - a0, 8);
    ctl_write(32'h680 | 32'h4 | CH);
    idle(40);
    check("R11 idle dump length", rd(32'h68C), 32'd0);
    check("R11 idle dump address", rd(32'h684), 32'h820);
    check("R11 idle dump status", rd(32'h69C), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule